// File: doc/BRIEF.md
# Half-Duplex SPI Command Engine

This block is an SPI host that runs one complete command each time software triggers it. A command is a single opcode byte, then a programmed number of transmit bytes, then a programmed number of receive bytes. All of them are clocked out under one chip-select assertion. The opcode sits in its own register. Transmit bytes are preloaded into a byte-addressed buffer. Receive bytes are written back into the same buffer, directly behind the transmit bytes, so that one contiguous window holds the whole payload of the command.

Software uses a small register bus. A word access to the control register at offset 0x00 triggers a command, clears the buffer stream pointer, or clears the sticky length error. Bit 31 of that register reports busy. Byte accesses reach the opcode, the counts, the device select, a streaming write port and the buffer window at 0x80. The wire side runs SPI mode 0, MSB first, with one chip-select line per attached device. Each SCLK half-period lasts `HALF_DIV` system clocks.

Top module: `spi_cmd_engine`

## Requirements
- R1: The opcode register (byte offset 0x04) is the first byte on MOSI for every command, sent MSB first. MOSI changes only while SCLK is low (on the falling edge), and MISO is sampled on the rising edge.
- R2: A command produces exactly one chip-select pulse carrying 8 × (1 + eff_tx + eff_rx) SCLK rising edges. The counts come from offset 0x05 (tx) and 0x06 (rx).
- R3: After the opcode, buffer bytes 0 to eff_tx−1 (bus offsets 0x80 upward) are sent in increasing address order.
- R4: Receive byte j is stored at buffer position eff_tx + j. Nothing is captured during the opcode or transmit phase, and buffer bytes outside the receive window are left unchanged.
- R5: A word write with bit 16 set at offset 0x00 starts a command. Bit 16 always reads 0. Bit 31 reads 1 from the cycle after the trigger until the chip select is released, and it is never 0 while a line is still low.
- R6: While busy, every bus write is ignored. This covers a second trigger, the opcode, counts, select, buffer, stream port and control bits.
- R7: The select field (offset 0x07, bits [1:0]) picks one of the chip-select lines. Only that line is low during the command, and all lines are high when idle.
- R8: Chip select falls exactly one half-period (HALF_DIV clocks) before the first rising SCLK edge. It rises exactly one half-period after the last falling edge.
- R9: If tx + rx exceeds 70, then eff_tx = min(tx, 70) and eff_rx = 70 − eff_tx, and control bit 29 becomes 1. It stays 1 until a word write with bit 29 set at offset 0x00. Otherwise eff_tx = tx and eff_rx = rx.
- R10: A byte write to offset 0x08 stores the byte at the buffer stream pointer and increments the pointer. Reading 0x08 returns the pointer. A word write with bit 20 set at 0x00 returns the pointer to 0.
- R11: After reset the control word reads 0, the stream pointer and opcode read 0, all chip selects are high, and SCLK and MOSI are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data (byte accesses use bits 7:0) |
| bus_we | input | 1 | Write strobe, one access per clock |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Host-to-device data |
| spi_miso | input | 1 | Device-to-host data |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
A wrong byte index or phase boundary shows up on the wire within one byte time: the captured opcode, the transmit stream or the bit count per chip-select pulse differs from the model. After busy clears, the same fault shows in the buffer as a receive byte shifted by one position or as an overwritten transmit byte. A stuck or mis-latched sequencer state appears as busy never clearing, busy clearing while a line is still low, or lead and trail gaps that are not one half-period. A broken lockout appears as a second chip-select pulse or a changed opcode read back after the command.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   // register byte offsets
   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_OPC  = 8'h04;
   localparam logic [7:0] OFS_TXN  = 8'h05;
   localparam logic [7:0] OFS_RXN  = 8'h06;
   localparam logic [7:0] OFS_SEL  = 8'h07;
   localparam logic [7:0] OFS_PORT = 8'h08;
   localparam logic [7:0] BUF_BASE = 8'h80;

   // control word bit positions
   localparam int unsigned CTL_EXEC = 16;
   localparam int unsigned CTL_PCLR = 20;
   localparam int unsigned CTL_ERR  = 29;
   localparam int unsigned CTL_BUSY = 31;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_TAIL = 2'd2
   } seq_state_t;

   typedef struct packed {
      logic [7:0] opcode;
      logic [7:0] tx_n;
      logic [7:0] rx_n;
   } cmd_cfg_t;

endpackage

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
   parameter int unsigned HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   initial begin
      assert (HALF_DIV >= 1) else $error("HALF_DIV must be at least 1");
   end

   generate
      if (HALF_DIV == 1) begin : g_every
         assign tick = run;
      end else begin : g_cnt
         localparam int unsigned CW = $clog2(HALF_DIV);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (!run || tick) cnt <= '0;
            else                   cnt <= cnt + 1'b1;
         end

         assign tick = run && (cnt == CW'(HALF_DIV - 1));

         // half-periods are at least two clocks long in this variant
         assert_tick_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
   import spi_cmd_pkg::*;
#(
   parameter int unsigned BUF_BYTES = 70,
   parameter int unsigned NUM_CS    = 4,
   localparam int unsigned IDX_W    = $clog2(BUF_BYTES + 2),
   localparam int unsigned SEL_W    = $clog2(NUM_CS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   input  logic             bus_we,
   input  logic             bus_word,
   output logic [31:0]      bus_rdata,
   input  logic             busy,
   input  logic             clip,
   input  logic [IDX_W-1:0] eng_rd_idx,
   output logic [7:0]       eng_rd_data,
   input  logic             eng_we,
   input  logic [IDX_W-1:0] eng_widx,
   input  logic [7:0]       eng_wdata,
   output logic             start,
   output cmd_cfg_t         cmd,
   output logic [SEL_W-1:0] sel
);

   localparam int unsigned AW = $clog2(BUF_BYTES);

   logic [7:0]       mem [BUF_BYTES];
   logic [7:0]       opc_q, txn_q, rxn_q;
   logic [SEL_W-1:0] sel_q;
   logic [IDX_W-1:0] ptr_q;
   logic             err_q;

   logic             wr_ok, ctrl_wr, pclr, errclr, port_wr, buf_hit;
   logic [7:0]       buf_off, wbyte;
   logic             wdata_unused;

   assign wdata_unused = ^bus_wdata;
   assign wbyte   = bus_wdata[7:0];
   assign wr_ok   = bus_we && !busy;
   assign ctrl_wr = wr_ok && bus_word && (bus_addr == OFS_CTRL);
   assign start   = ctrl_wr && bus_wdata[CTL_EXEC];
   assign pclr    = ctrl_wr && bus_wdata[CTL_PCLR];
   assign errclr  = ctrl_wr && bus_wdata[CTL_ERR];
   assign buf_off = bus_addr - BUF_BASE;
   assign buf_hit = (bus_addr >= BUF_BASE) && (buf_off < 8'(BUF_BYTES));
   assign port_wr = wr_ok && (bus_addr == OFS_PORT) && (ptr_q < IDX_W'(BUF_BYTES));

   // buffer storage: engine receive writes and bus writes never overlap (bus locked while busy)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < BUF_BYTES; i++) mem[i] <= '0;
      end else begin
         for (int i = 0; i < BUF_BYTES; i++) begin
            if (eng_we && eng_widx == IDX_W'(i))
               mem[i] <= eng_wdata;
            else if (wr_ok && buf_hit && buf_off == 8'(i))
               mem[i] <= wbyte;
            else if (port_wr && ptr_q == IDX_W'(i))
               mem[i] <= wbyte;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opc_q <= '0;
         txn_q <= '0;
         rxn_q <= '0;
         sel_q <= '0;
         ptr_q <= '0;
         err_q <= 1'b0;
      end else begin
         if (wr_ok && bus_addr == OFS_OPC) opc_q <= wbyte;
         if (wr_ok && bus_addr == OFS_TXN) txn_q <= wbyte;
         if (wr_ok && bus_addr == OFS_RXN) rxn_q <= wbyte;
         if (wr_ok && bus_addr == OFS_SEL) sel_q <= bus_wdata[SEL_W-1:0];
         if (pclr)         ptr_q <= '0;
         else if (port_wr) ptr_q <= ptr_q + 1'b1;
         if (clip)         err_q <= 1'b1;
         else if (errclr)  err_q <= 1'b0;
      end
   end

   assign eng_rd_data = (eng_rd_idx < IDX_W'(BUF_BYTES)) ? mem[eng_rd_idx[AW-1:0]] : 8'h00;
   assign cmd = '{opcode: opc_q, tx_n: txn_q, rx_n: rxn_q};
   assign sel = sel_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CTRL: begin
            bus_rdata[CTL_BUSY] = busy;
            bus_rdata[CTL_ERR]  = err_q;
         end
         OFS_OPC:  bus_rdata[7:0] = opc_q;
         OFS_TXN:  bus_rdata[7:0] = txn_q;
         OFS_RXN:  bus_rdata[7:0] = rxn_q;
         OFS_SEL:  bus_rdata[SEL_W-1:0] = sel_q;
         OFS_PORT: bus_rdata[IDX_W-1:0] = ptr_q;
         default:  if (buf_hit) bus_rdata[7:0] = mem[buf_off[AW-1:0]];
      endcase
   end

   assert_cfg_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> ($stable(opc_q) && $stable(txn_q) && $stable(rxn_q) && $stable(ptr_q)));

   assert_trigger_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   assert_ptr_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= IDX_W'(BUF_BYTES));

   assert_err_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(clip));

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
   import spi_cmd_pkg::*;
#(
   parameter int unsigned BUF_BYTES = 70,
   parameter int unsigned NUM_CS    = 4,
   localparam int unsigned IDX_W    = $clog2(BUF_BYTES + 2),
   localparam int unsigned SEL_W    = $clog2(NUM_CS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  cmd_cfg_t          cmd,
   input  logic [SEL_W-1:0]  sel,
   input  logic              tick,
   input  logic [7:0]        rd_data,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [7:0]        wr_data,
   output logic              clip,
   output logic              busy,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_n
);

   seq_state_t       state;
   logic             sclk_q, mosi_q;
   logic [2:0]       bit_cnt;
   logic [IDX_W-1:0] byte_idx, last_q, txe_q;
   logic [SEL_W-1:0] sel_q;
   logic [7:0]       tx_sr, rx_sr, nbyte;

   logic [8:0]       sum;
   logic             over;
   logic [IDX_W-1:0] eff_tx, last_idx;
   logic             rx_phase, byte_end;

   // length clipping at trigger time
   assign sum      = {1'b0, cmd.tx_n} + {1'b0, cmd.rx_n};
   assign over     = sum > 9'(BUF_BYTES);
   assign eff_tx   = (over && cmd.tx_n > 8'(BUF_BYTES)) ? IDX_W'(BUF_BYTES) : IDX_W'(cmd.tx_n);
   assign last_idx = over ? IDX_W'(BUF_BYTES) : IDX_W'(sum);
   assign clip     = start && over;

   assign rx_phase = byte_idx > txe_q;
   assign byte_end = tick && sclk_q && (bit_cnt == 3'd7);
   assign rd_idx   = byte_idx;
   assign nbyte    = (byte_idx < txe_q) ? rd_data : 8'h00;

   assign wr_en    = (state == ST_RUN) && byte_end && rx_phase;
   assign wr_idx   = byte_idx - 1'b1;
   assign wr_data  = rx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sclk_q   <= 1'b0;
         mosi_q   <= 1'b0;
         bit_cnt  <= '0;
         byte_idx <= '0;
         last_q   <= '0;
         txe_q    <= '0;
         sel_q    <= '0;
         tx_sr    <= '0;
         rx_sr    <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               state    <= ST_RUN;
               sel_q    <= sel;
               byte_idx <= '0;
               last_q   <= last_idx;
               txe_q    <= eff_tx;
               tx_sr    <= cmd.opcode;
               mosi_q   <= cmd.opcode[7];
               bit_cnt  <= '0;
               sclk_q   <= 1'b0;
               rx_sr    <= '0;
            end
            ST_RUN: if (tick) begin
               if (!sclk_q) begin
                  sclk_q <= 1'b1;
                  if (rx_phase) rx_sr <= {rx_sr[6:0], miso};
               end else begin
                  sclk_q <= 1'b0;
                  if (bit_cnt == 3'd7) begin
                     bit_cnt <= '0;
                     if (byte_idx == last_q) begin
                        state  <= ST_TAIL;
                        mosi_q <= 1'b0;
                     end else begin
                        byte_idx <= byte_idx + 1'b1;
                        tx_sr    <= nbyte;
                        mosi_q   <= nbyte[7];
                     end
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                     tx_sr   <= {tx_sr[6:0], 1'b0};
                     mosi_q  <= tx_sr[6];
                  end
               end
            end
            ST_TAIL: if (tick) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);
   assign sclk = sclk_q;
   assign mosi = mosi_q;

   genvar g;
   generate
      for (g = 0; g < NUM_CS; g++) begin : g_cs
         assign cs_n[g] = !(busy && sel_q == SEL_W'(g));
      end
   endgenerate

   assert_one_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (&cs_n && !sclk));

   assert_rx_after_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx >= txe_q));

   assert_len_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (byte_idx <= last_q && last_q <= IDX_W'(BUF_BYTES)));

   assert_sclk_paced_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(sclk));

   assert_mosi_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int unsigned BUF_BYTES = 70,
   parameter int unsigned NUM_CS    = 4,
   parameter int unsigned HALF_DIV  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_we,
   input  logic              bus_word,
   output logic [31:0]       bus_rdata,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_cs_n
);

   localparam int unsigned IDX_W = $clog2(BUF_BYTES + 2);
   localparam int unsigned SEL_W = $clog2(NUM_CS);

   initial begin
      assert (BUF_BYTES >= 2 && BUF_BYTES <= 128) else $error("BUF_BYTES out of range");
      assert (NUM_CS >= 2 && NUM_CS <= 256) else $error("NUM_CS out of range");
   end

   logic             start, clip, busy, tick, eng_we;
   cmd_cfg_t         cmd;
   logic [SEL_W-1:0] sel;
   logic [IDX_W-1:0] rd_idx, wr_idx;
   logic [7:0]       rd_data, wr_data;

   spi_cmd_regs #(.BUF_BYTES(BUF_BYTES), .NUM_CS(NUM_CS)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_we      (bus_we),
      .bus_word    (bus_word),
      .bus_rdata   (bus_rdata),
      .busy        (busy),
      .clip        (clip),
      .eng_rd_idx  (rd_idx),
      .eng_rd_data (rd_data),
      .eng_we      (eng_we),
      .eng_widx    (wr_idx),
      .eng_wdata   (wr_data),
      .start       (start),
      .cmd         (cmd),
      .sel         (sel)
   );

   spi_cmd_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .tick  (tick)
   );

   spi_cmd_seq #(.BUF_BYTES(BUF_BYTES), .NUM_CS(NUM_CS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .cmd     (cmd),
      .sel     (sel),
      .tick    (tick),
      .rd_data (rd_data),
      .rd_idx  (rd_idx),
      .wr_en   (eng_we),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .clip    (clip),
      .busy    (busy),
      .sclk    (spi_sclk),
      .mosi    (spi_mosi),
      .miso    (spi_miso),
      .cs_n    (spi_cs_n)
   );

endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;

   localparam int BUF = 70;
   localparam int NCS = 4;
   localparam int HD  = 2;
   localparam int PER = 20;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [7:0]     addr = '0;
   logic [31:0]    wdata = '0;
   logic           we = 1'b0;
   logic           word = 1'b0;
   logic [31:0]    rdata;
   logic           sclk, mosi;
   logic           miso = 1'b0;
   logic [NCS-1:0] cs_n;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   spi_cmd_engine #(.BUF_BYTES(BUF), .NUM_CS(NCS), .HALF_DIV(HD)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
      .bus_word(word), .bus_rdata(rdata), .spi_sclk(sclk), .spi_mosi(mosi),
      .spi_miso(miso), .spi_cs_n(cs_n)
   );

   // ---------------- device model ----------------
   int          salt = 0;
   int          bitn = 0, cs_falls = 0, sel_seen = -1, cs_bad = 0;
   longint      t_fall = 0, t_rise1 = 0, t_lastfall = 0, t_csup = 0;
   logic [7:0]  cap [80];
   logic        p_act = 1'b0, p_sclk = 1'b0;
   wire         act = ~&cs_n;

   function automatic logic [7:0] resp(int b);
      return 8'(((b * 29) + (salt * 7) + 61) ^ 170);
   endfunction

   function automatic logic rbit(int n);
      logic [7:0] r;
      r = resp(n / 8);
      return r[7 - (n % 8)];
   endfunction

   always @(act or sclk) begin
      if (act && !p_act) begin
         bitn = 0; cs_falls++; t_fall = $time; sel_seen = -1;
         for (int i = 0; i < NCS; i++) if (!cs_n[i]) sel_seen = i;
         miso = rbit(0);
      end else if (!act && p_act) begin
         t_csup = $time;
      end else if (act && sclk && !p_sclk) begin
         if (bitn == 0) t_rise1 = $time;
         if (sel_seen < 0 || cs_n != ~(4'b0001 << sel_seen)) cs_bad++;
         if (bitn / 8 < 80) cap[bitn / 8][7 - (bitn % 8)] = mosi;
         bitn++;
      end else if (act && !sclk && p_sclk) begin
         t_lastfall = $time;
         miso = rbit(bitn);
      end
      p_act = act;
      p_sclk = sclk;
   end

   // ---------------- bench helpers ----------------
   logic [7:0] mdl [BUF];

   task automatic check(input string req, input longint act_v, input longint exp_v);
      checks++;
      if (act_v != exp_v) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic w);
      @(negedge clk);
      addr = a; wdata = d; word = w; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      addr = a; we = 1'b0; word = 1'b0;
      #1 v = rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      int n = 0;
      do begin
         rd(8'h00, v);
         n++;
      end while (v[31] && n < 50000);
      check("R5 busy eventually clears", v[31], 0);
      check("R5 lines released once idle", cs_n, 4'hF);
   endtask

   task automatic run_cmd(input int opc, input int tx, input int rx, input int sel);
      logic [31:0] v;
      int f0, etx, erx, mism;
      bit ov;
      for (int i = 0; i < BUF; i++) begin
         mdl[i] = 8'($urandom);
         wr(8'(8'h80 + i), {24'h0, mdl[i]}, 1'b0);
      end
      wr(8'h04, 32'(opc), 1'b0);
      wr(8'h05, 32'(tx), 1'b0);
      wr(8'h06, 32'(rx), 1'b0);
      wr(8'h07, 32'(sel), 1'b0);
      salt++;
      f0 = cs_falls;
      wr(8'h00, 32'h0001_0000, 1'b1);
      rd(8'h00, v);
      check("R5 busy after trigger", v[31], 1);
      check("R5 trigger bit reads 0", v[16], 0);
      wait_idle();
      ov  = (tx + rx) > BUF;
      etx = ov ? ((tx > BUF) ? BUF : tx) : tx;
      erx = ov ? (BUF - etx) : rx;
      check("R2 one select pulse", cs_falls - f0, 1);
      check("R2 wire bit count", bitn, 8 * (1 + etx + erx));
      check("R1 opcode first", cap[0], opc);
      mism = 0;
      for (int i = 0; i < etx; i++) if (cap[1 + i] !== mdl[i]) mism++;
      check("R3 transmit byte mismatches", mism, 0);
      mism = 0;
      for (int i = 0; i < BUF; i++) begin
         rd(8'(8'h80 + i), v);
         if (i >= etx && i < etx + erx) begin
            if (v[7:0] !== resp(1 + i)) mism++;
         end else if (v[7:0] !== mdl[i]) mism++;
      end
      check("R4 buffer content mismatches", mism, 0);
      check("R7 selected line", sel_seen, sel);
      check("R7 other lines high", cs_bad, 0);
      check("R8 lead gap", t_rise1 - t_fall, HD * PER);
      check("R8 trail gap", t_csup - t_lastfall, HD * PER);
      rd(8'h00, v);
      check("R9 clip flag", v[29], ov);
      if (ov) begin
         wr(8'h00, 32'h2000_0000, 1'b1);
         rd(8'h00, v);
         check("R9 clip flag cleared", v[29], 0);
      end
   endtask

   // ---------------- main sequence ----------------
   initial begin
      logic [31:0] v;
      int f0;
      void'($urandom(32'd20241));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      rd(8'h00, v); check("R11 control after reset", v, 0);
      rd(8'h08, v); check("R11 pointer after reset", v, 0);
      rd(8'h04, v); check("R11 opcode after reset", v, 0);
      check("R11 selects high", cs_n, 4'hF);
      check("R11 sclk low", sclk, 0);
      check("R11 mosi low", mosi, 0);

      // R10 stream port and pointer clear
      wr(8'h08, 32'hA1, 1'b0);
      wr(8'h08, 32'hB2, 1'b0);
      wr(8'h08, 32'hC3, 1'b0);
      rd(8'h08, v); check("R10 pointer advanced", v, 3);
      wr(8'h00, 32'h0010_0000, 1'b1);
      rd(8'h08, v); check("R10 pointer cleared", v, 0);
      wr(8'h08, 32'hD4, 1'b0);
      wr(8'h08, 32'hE5, 1'b0);
      rd(8'h80, v); check("R10 restart overwrote byte 0", v, 32'hD4);
      rd(8'h81, v); check("R10 restart overwrote byte 1", v, 32'hE5);
      rd(8'h82, v); check("R10 byte 2 kept", v, 32'hC3);

      // directed corners
      run_cmd(8'h9F, 0, 0, 0);
      run_cmd(8'h02, BUF, 0, 1);
      run_cmd(8'h0B, 0, BUF, 2);
      run_cmd(8'h3C, 50, 50, 3);
      run_cmd(8'h5A, 80, 5, 1);
      run_cmd(8'hC7, 3, 255, 2);

      // R6 lockout during a command
      run_cmd(8'h96, 2, 2, 1);
      for (int i = 0; i < BUF; i++) wr(8'(8'h80 + i), {24'h0, mdl[i]}, 1'b0);
      f0 = cs_falls;
      wr(8'h00, 32'h0001_0000, 1'b1);
      repeat (6) @(negedge clk);
      wr(8'h04, 32'h11, 1'b0);
      wr(8'h80, {24'h0, ~mdl[0]}, 1'b0);
      wr(8'h08, 32'h77, 1'b0);
      wr(8'h00, 32'h0001_0000, 1'b1);
      wait_idle();
      repeat (20) @(negedge clk);
      rd(8'h00, v); check("R6 no second command", v[31], 0);
      check("R6 single pulse", cs_falls - f0, 1);
      rd(8'h04, v); check("R6 opcode kept", v, 32'h96);
      rd(8'h80, v); check("R6 buffer byte kept", v[7:0], mdl[0]);
      rd(8'h08, v); check("R6 pointer kept", v, 2);
      check("R3 original byte sent", cap[1], mdl[0]);

      // constrained random commands
      for (int k = 0; k < 10; k++) begin
         run_cmd(int'($urandom % 256), int'($urandom % 45), int'($urandom % 45),
                 int'($urandom % NCS));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule